// File: doc/BRIEF.md
# Conversion Result Byte Reader

This block sits between a 12-bit converter and an 8-bit processor bus. It watches the converter's busy flag. When that flag falls, it latches the result. A processor then fetches the result as two separate byte reads. Each read uses its own select line, qualified by an active-low read strobe. The block drives the bus only during a valid read. The enable of the tri-state buffers is brought out as a port, and the data lines read zero whenever that enable is low.

Two packings are available. In left-justified packing, the high byte carries the eight most significant bits, so a single read gives a coarse sample. The low byte carries the four remaining bits in its upper nybble and the busy status in bit 0. In right-justified packing, the low byte carries the eight least significant bits. The high byte carries the four top bits in its lower nybble and the busy status in bit 7. A coding input inverts the result's top bit, which turns offset-binary bipolar data into two's complement.

A result that arrives while the read strobe is low is parked, so the value seen by the processor never changes under an access. The parked value is installed on the first clock after the strobe returns high.

Top module: `result_byte_reader`

## Requirements
- R1: After reset the latched result is 0, the status bit reads 0 and `busOe` is low.
- R2: `busOe` is high only when `rdN` is 0 and exactly one of `selHi`/`selLo` is 1. Whenever `busOe` is low, `busData` is 0.
- R3: With `leftJust`=1, the high byte is result bits [11:4].
- R4: With `leftJust`=1, the low byte is {result[3:0], 3'b000, status}. The status bit is bit 0.
- R5: With `leftJust`=0, the low byte is result bits [7:0].
- R6: With `leftJust`=0, the high byte is {status, 3'b000, result[11:8]}. The status bit is bit 7.
- R7: With `twosComp`=1, result bit 11 is presented inverted wherever it appears: bit 7 of the high byte in left packing, bit 3 of the high byte in right packing.
- R8: The result is captured at a clock edge where `convBusy` is 0 and was 1 at the previous edge. A rising or steady `convBusy` leaves the latched result unchanged.
- R9: The status bit equals `convBusy` as sampled at the previous clock edge.
- R10: A capture that occurs while `rdN` is 0 does not change the bus value during that read. It becomes visible one clock after `rdN` returns to 1.
- R11: If several captures occur during one read, the last one is the value installed after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convResult | input | 12 | Converter result, valid when busy falls |
| convBusy | input | 1 | Converter busy flag, high during conversion |
| rdN | input | 1 | Active-low read strobe |
| selHi | input | 1 | High-byte select |
| selLo | input | 1 | Low-byte select |
| leftJust | input | 1 | 1 = left-justified packing, 0 = right-justified |
| twosComp | input | 1 | 1 = invert result MSB on the bus |
| busData | output | 8 | Byte presented to the bus, 0 when not driven |
| busOe | output | 1 | Enable for the external bus buffers |

## Verification
The latch, the parked copy and the pending flag are not visible directly. They show up as byte values on the next read.

A capture missed on the busy fall leaves stale data on the very next access. A parked value that is lost, or installed too early, shows up as a changed byte inside a read, or as an old byte on the first read after the strobe rises. A lagging or stuck status register gives a wrong status bit one clock after `convBusy` toggles.

// File: rtl/result_byte_pkg.sv
package result_byte_pkg;
  typedef struct packed {
    logic capNow;      // install converter value into result latch
    logic stashNow;    // park converter value, read in progress
    logic applyStash;  // move parked value into result latch
    logic driveHi;     // present high byte
    logic driveLo;     // present low byte
  } strobe_t;
endpackage

// File: rtl/result_byte_ctrl.sv
module result_byte_ctrl
  import result_byte_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    convBusy,
  input  logic    rdN,
  input  logic    selHi,
  input  logic    selLo,
  output strobe_t strobes,
  output logic    statusBit
);
  logic busyQ;
  logic pendQ;
  logic fallSeen;
  logic reading;

  assign fallSeen = busyQ & ~convBusy;
  assign reading  = ~rdN;

  always_comb begin
    strobes.capNow     = fallSeen & ~reading;
    strobes.stashNow   = fallSeen & reading;
    // a fresh capture outside a read supersedes any parked value
    strobes.applyStash = pendQ & ~reading & ~fallSeen;
    strobes.driveHi    = reading & selHi & ~selLo;
    strobes.driveLo    = reading & selLo & ~selHi;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      busyQ <= convBusy;
      if (strobes.stashNow)
        pendQ <= 1'b1;
      else if (!reading)
        pendQ <= 1'b0;
    end
  end

  assign statusBit = busyQ;
endmodule

// File: rtl/result_byte_dp.sv
module result_byte_dp
  import result_byte_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RES_W-1:0] convResult,
  input  strobe_t          strobes,
  input  logic             statusBit,
  input  logic             leftJust,
  input  logic             twosComp,
  output logic [BUS_W-1:0] busData,
  output logic             busOe
);
  localparam int NIB_W = RES_W - BUS_W;
  localparam int PAD_W = BUS_W - NIB_W - 1;

  logic [RES_W-1:0] resultQ;
  logic [RES_W-1:0] stashQ;
  logic [RES_W-1:0] coded;
  logic [BUS_W-1:0] hiByte;
  logic [BUS_W-1:0] loByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      stashQ  <= '0;
    end else begin
      if (strobes.stashNow)
        stashQ <= convResult;
      if (strobes.capNow)
        resultQ <= convResult;
      else if (strobes.applyStash)
        resultQ <= stashQ;
    end
  end

  assign coded = {resultQ[RES_W-1] ^ twosComp, resultQ[RES_W-2:0]};

  always_comb begin
    if (leftJust) begin
      hiByte = coded[RES_W-1 -: BUS_W];
      loByte = {coded[NIB_W-1:0], {PAD_W{1'b0}}, statusBit};
    end else begin
      hiByte = {statusBit, {PAD_W{1'b0}}, coded[RES_W-1:BUS_W]};
      loByte = coded[BUS_W-1:0];
    end
  end

  assign busOe   = strobes.driveHi | strobes.driveLo;
  assign busData = strobes.driveHi ? hiByte :
                   strobes.driveLo ? loByte : '0;
endmodule

// File: rtl/result_byte_reader.sv
module result_byte_reader
  import result_byte_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RES_W-1:0] convResult,
  input  logic             convBusy,
  input  logic             rdN,
  input  logic             selHi,
  input  logic             selLo,
  input  logic             leftJust,
  input  logic             twosComp,
  output logic [BUS_W-1:0] busData,
  output logic             busOe
);
  strobe_t strobes;
  logic    statusBit;

  result_byte_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .convBusy  (convBusy),
    .rdN       (rdN),
    .selHi     (selHi),
    .selLo     (selLo),
    .strobes   (strobes),
    .statusBit (statusBit)
  );

  result_byte_dp #(.RES_W(RES_W), .BUS_W(BUS_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .convResult (convResult),
    .strobes    (strobes),
    .statusBit  (statusBit),
    .leftJust   (leftJust),
    .twosComp   (twosComp),
    .busData    (busData),
    .busOe      (busOe)
  );
endmodule

// File: rtl/result_byte_reader_chk.sv
module result_byte_reader_chk (
  input logic       clk,
  input logic       rstN,
  input logic       convBusy,
  input logic       rdN,
  input logic       selHi,
  input logic       selLo,
  input logic       leftJust,
  input logic       twosComp,
  input logic [7:0] busData,
  input logic       busOe
);
  logic busySeen;
  always_ff @(posedge clk) begin
    if (!rstN) busySeen <= 1'b0;
    else       busySeen <= convBusy;
  end

  AST_OE_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (!rdN && (selHi != selLo))) else $error("oe"); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> (busData == 8'h00)) else $error("idle"); // R2
  AST_LEFT_PAD: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && selLo && leftJust) |-> (busData[3:1] == 3'b000)) else $error("lpad"); // R4
  AST_RIGHT_PAD: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && selHi && !leftJust) |-> (busData[6:4] == 3'b000)) else $error("rpad"); // R6
  AST_STATUS_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && selLo && leftJust) |-> (busData[0] == busySeen)) else $error("stl"); // R9
  AST_STATUS_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && selHi && !leftJust) |-> (busData[7] == busySeen)) else $error("str"); // R9
  AST_HOLD_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && selHi && leftJust && $past(busOe && selHi && leftJust)
     && $stable(twosComp)) |-> $stable(busData)) else $error("hold"); // R10
endmodule

bind result_byte_reader result_byte_reader_chk i_chk (.*);

// File: tb/test_result_byte_reader.sv
module test_result_byte_reader;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] convResult = 12'h000;
  logic        convBusy = 1'b0;
  logic        rdN = 1'b1;
  logic        selHi = 1'b0;
  logic        selLo = 1'b0;
  logic        leftJust = 1'b1;
  logic        twosComp = 1'b0;
  logic [7:0]  busData;
  logic        busOe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  result_byte_reader i_result_byte_reader (.*);

  function automatic logic [7:0] expByte(input logic [11:0] r, input bit hi,
                                         input bit left, input bit twos, input bit st);
    logic [11:0] c;
    c = {r[11] ^ twos, r[10:0]};
    if (left) return hi ? c[11:4] : {c[3:0], 3'b000, st};
    return hi ? {st, 3'b000, c[11:8]} : c[7:0];
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive a read at the negedge, sample 1 ns later, release at next negedge
  task automatic readByte(input string req, input bit hi, input logic [7:0] exp);
    @(negedge clk);
    rdN = 1'b0; selHi = hi; selLo = ~hi;
    #1;
    check(req, {busOe, busData}, {1'b1, exp});
    @(negedge clk);
    rdN = 1'b1; selHi = 1'b0; selLo = 1'b0;
  endtask

  // busy high two cycles, then fall with value v; latched at the next posedge
  task automatic convert(input logic [11:0] v);
    @(negedge clk);
    convBusy = 1'b1; convResult = ~v;
    repeat (2) @(negedge clk);
    convBusy = 1'b0; convResult = v;
    @(negedge clk);
    convResult = 12'h5A5;
  endtask

  task automatic t_reset;
    #1;
    check("R1 oe", {1'b0, busOe, 7'h0}, 9'h0);
    leftJust = 1'b1;
    readByte("R1 hi", 1'b1, 8'h00);
    readByte("R1 lo", 1'b0, 8'h00);
  endtask

  task automatic t_select;
    @(negedge clk);
    rdN = 1'b0; selHi = 1'b1; selLo = 1'b1; #1;
    check("R2 both", {busOe, busData}, 9'h000);
    selHi = 1'b0; selLo = 1'b0; #1;
    check("R2 none", {busOe, busData}, 9'h000);
    rdN = 1'b1; selHi = 1'b1; #1;
    check("R2 nostrobe", {busOe, busData}, 9'h000);
    selHi = 1'b0;
  endtask

  task automatic t_packing(input logic [11:0] v);
    convert(v);
    leftJust = 1'b1; twosComp = 1'b0;
    readByte("R3", 1'b1, expByte(v, 1, 1, 0, 0));
    readByte("R4", 1'b0, expByte(v, 0, 1, 0, 0));
    leftJust = 1'b0;
    readByte("R5", 1'b0, expByte(v, 0, 0, 0, 0));
    readByte("R6", 1'b1, expByte(v, 1, 0, 0, 0));
    twosComp = 1'b1;
    readByte("R7 right", 1'b1, expByte(v, 1, 0, 1, 0));
    leftJust = 1'b1;
    readByte("R7 left", 1'b1, expByte(v, 1, 1, 1, 0));
    twosComp = 1'b0;
  endtask

  task automatic t_edges;
    convert(12'h3C7);
    @(negedge clk);
    convResult = 12'hFFF; convBusy = 1'b1;
    @(negedge clk);
    // R9 status follows busy sampled one edge earlier
    readByte("R9 busy", 1'b0, expByte(12'h3C7, 0, 1, 0, 1));
    readByte("R8 rise", 1'b1, expByte(12'h3C7, 1, 1, 0, 0));
    convBusy = 1'b0; convResult = 12'h81E;
    @(negedge clk);
    convResult = 12'h000;
    repeat (3) @(negedge clk);
    readByte("R8 fall", 1'b1, expByte(12'h81E, 1, 1, 0, 0));
    readByte("R9 idle", 1'b0, expByte(12'h81E, 0, 1, 0, 0));
  endtask

  task automatic t_deferred;
    @(negedge clk);
    convBusy = 1'b1;
    @(negedge clk);
    rdN = 1'b0; selHi = 1'b1; selLo = 1'b0; leftJust = 1'b1;
    convBusy = 1'b0; convResult = 12'hC3A;
    @(negedge clk); #1;
    check("R10 during", {busOe, busData}, {1'b1, 8'h81});
    @(negedge clk); #1;
    check("R10 still", {busOe, busData}, {1'b1, 8'h81});
    rdN = 1'b1; selHi = 1'b0;
    @(negedge clk);
    readByte("R10 after", 1'b1, 8'hC3);
  endtask

  task automatic t_double;
    @(negedge clk);
    rdN = 1'b0; selLo = 1'b1; leftJust = 1'b0;
    convBusy = 1'b1;
    @(negedge clk); convBusy = 1'b0; convResult = 12'h111;
    @(negedge clk); convBusy = 1'b1;
    @(negedge clk); convBusy = 1'b0; convResult = 12'h2E9;
    @(negedge clk); #1;
    check("R11 during", {busOe, busData}, {1'b1, 8'h3A});
    rdN = 1'b1; selLo = 1'b0;
    @(negedge clk);
    readByte("R11 lo", 1'b0, 8'hE9);
    readByte("R11 hi", 1'b1, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_select();
    t_packing(12'h9B4);
    t_packing(12'h06F);
    t_edges();
    t_deferred();
    t_double();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule